// File: doc/BRIEF.md
# Video Output Bus Formatter

This block sits at the end of a video decode pipeline. It takes one decoded pixel per clock (8-bit luma plus 8-bit Cb and Cr) with a valid strobe, and drives two 8-bit output buses. The Y bus always carries luma. The C bus carries chroma in one of two layouts:

- **4:2:2:** Cb and Cr alternate, one per pixel.
- **4:1:1:** each four-pixel group carries one Cb and one Cr, packed two bits at a time into the upper half of the bus.

Before formatting, the block can replace pixel values:

- Chroma is forced to its zero level when the colour killer is forced or flagged.
- A fixed blue picture is substituted when automatic blue-screen is enabled and sync is lost.

Each bus then passes through its own short delay line. A per-bus 2-bit phase code moves that bus one clock earlier, one clock later or two clocks later than nominal. A separate enable output tells the pads whether to drive the buses or float them.

A small state machine tracks the chroma slot of the next valid pixel. Its states are:

- **S_LEAD:** the next valid pixel opens a line or a group. It is a Cb slot in 4:2:2 and nibble slot 0 in 4:1:1.
- **S_CR:** the next pixel is a Cr slot.
- **S_Q1, S_Q2, S_Q3:** nibble slots 1 to 3 of a 4:1:1 group.

Its transitions are:

- Any cycle without a valid pixel returns the machine to S_LEAD.
- In 4:2:2, a valid pixel moves any state other than S_CR to S_CR, and moves S_CR back to S_LEAD.
- In 4:1:1, a valid pixel steps S_LEAD or S_CR to S_Q1, then S_Q1 to S_Q2, S_Q2 to S_Q3, and S_Q3 to S_LEAD.

Top module: `vid_out_fmt`

## Requirements
- R1: When the pixel valid strobe is low, the formatted pixel is blanking: Y code 16 and C code 128.
- R2: With fmt_411 = 0 (4:2:2), the C bus carries Cb on the first valid pixel after any gap, then Cr and Cb alternately; the Y bus carries each pixel's luma.
- R3: With fmt_411 = 1 (4:1:1), valid pixels form groups of four, starting at the first valid pixel after a gap. Cb and Cr are taken from the group's first pixel. For pixel k of the group (k = 0..3), C[7:6] holds Cb bits [7-2k:6-2k], C[5:4] holds Cr bits [7-2k:6-2k], and C[3:0] is 0.
- R4: A pixel presented at clock edge e appears on a bus after edge e+1 when that bus's phase code is 00 (nominal), after edge e for code 01, after edge e+2 for code 11, and after edge e+3 for code 10.
- R5: The Y phase code (y_phase) and the C phase code (c_phase) act independently; each bus follows only its own code.
- R6: With kill_force = 1, the Cb and Cr values of valid pixels are replaced by 128 before formatting; luma is unchanged.
- R7: With kill_flag = 1, chroma is replaced by 128 exactly as in R6.
- R8: With blue_auto = 1 and sync_ok = 0, valid pixels are replaced by Y = 29, Cb = 255, Cr = 107. This replacement takes precedence over colour killing.
- R9: With blue_auto = 0, decoded video is output whether or not sync_ok is set. With sync_ok = 1, blue_auto has no effect.
- R10: During reset, out_en is 0, the Y bus is 16 and the C bus is 128. Afterwards, out_en is 1 after an edge at which hiz is 0, and 0 after an edge at which hiz is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | High for active-video pixels |
| y_in | input | 8 | Decoded luma |
| cb_in | input | 8 | Decoded Cb |
| cr_in | input | 8 | Decoded Cr |
| fmt_411 | input | 1 | 0: 4:2:2 chroma, 1: 4:1:1 packed chroma |
| y_phase | input | 2 | Y bus timing code (00 nominal, 01 early 1, 10 late 2, 11 late 1) |
| c_phase | input | 2 | C bus timing code, same encoding |
| kill_force | input | 1 | Forced colour kill |
| kill_flag | input | 1 | Automatic colour-killer decision |
| blue_auto | input | 1 | Enable blue screen on sync loss |
| sync_ok | input | 1 | Sync currently detected |
| hiz | input | 1 | Request buses high impedance |
| y_out | output | 8 | Y output bus |
| c_out | output | 8 | C output bus |
| out_en | output | 1 | Pad drive enable for both buses |

## Verification
A wrong slot state shows up on the C bus at the next valid pixel. In 4:2:2 it appears as swapped Cb and Cr. In 4:1:1 it appears as a misplaced bit pair, visible within one group of four pixels. Such errors are easiest to expose right after a gap, so the streams insert gaps both mid-line and mid-group. A wrong delay tap shifts the whole stream by one to three pixels, so each phase code is checked against ramps that change every pixel, with different codes on the two buses in the same run. A stale 4:1:1 group register corrupts pairs 1 to 3 of the affected group only.

// File: rtl/vof_pkg.sv
package vof_pkg;
    localparam int DW = 8;
    localparam int PHASE_W = 2;
    localparam int QUAD_W = 2;

    localparam logic [DW-1:0] Y_BLANK = 8'd16;
    localparam logic [DW-1:0] C_ZERO  = 8'd128;
    localparam logic [DW-1:0] Y_BLUE  = 8'd29;
    localparam logic [DW-1:0] CB_BLUE = 8'd255;
    localparam logic [DW-1:0] CR_BLUE = 8'd107;

    typedef enum logic [2:0] {
        S_LEAD,
        S_CR,
        S_Q1,
        S_Q2,
        S_Q3
    } slot_state_t;
endpackage

// File: rtl/vof_slot_fsm.sv
module vof_slot_fsm
    import vof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              fmt_411,
    output logic              cr_slot,
    output logic [QUAD_W-1:0] quad_idx
);
    slot_state_t state_q;
    slot_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LEAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!pix_valid) begin
            state_d = S_LEAD;
        end else if (fmt_411) begin
            unique case (state_q)
                S_Q1:    state_d = S_Q2;
                S_Q2:    state_d = S_Q3;
                S_Q3:    state_d = S_LEAD;
                default: state_d = S_Q1;
            endcase
        end else begin
            unique case (state_q)
                S_CR:    state_d = S_LEAD;
                default: state_d = S_CR;
            endcase
        end
    end

    always_comb begin
        cr_slot  = 1'b0;
        quad_idx = '0;
        if (fmt_411) begin
            unique case (state_q)
                S_Q1:    quad_idx = 2'd1;
                S_Q2:    quad_idx = 2'd2;
                S_Q3:    quad_idx = 2'd3;
                default: quad_idx = 2'd0;
            endcase
        end else begin
            cr_slot = (state_q == S_CR);
        end
    end

    // R2, R3: a gap always restarts the slot sequence
    p_gap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (state_q == S_LEAD));

    // R3: the fourth pixel of a group closes it
    p_quad_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && fmt_411 && state_q == S_Q3) |=> (state_q == S_LEAD));
endmodule

// File: rtl/vof_pixel_fmt.sv
module vof_pixel_fmt
    import vof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [DW-1:0]     y_in,
    input  logic [DW-1:0]     cb_in,
    input  logic [DW-1:0]     cr_in,
    input  logic              fmt_411,
    input  logic              cr_slot,
    input  logic [QUAD_W-1:0] quad_idx,
    input  logic              kill,
    input  logic              blue_now,
    output logic [DW-1:0]     y_q,
    output logic [DW-1:0]     c_q
);
    localparam int PAD_W = DW - 4;

    logic [DW-1:0] sub_y, sub_cb, sub_cr;
    logic [DW-1:0] grp_cb, grp_cr;
    logic [DW-1:0] use_cb, use_cr;
    logic [1:0]    cb_pair, cr_pair;
    logic [DW-1:0] c_pix;

    function automatic logic [1:0] pick_pair(input logic [DW-1:0] v,
                                             input logic [QUAD_W-1:0] q);
        int hi;
        hi = (DW - 1) - 2 * int'(q);
        return v[hi -: 2];
    endfunction

    always_comb begin
        if (blue_now) begin
            sub_y  = Y_BLUE;
            sub_cb = CB_BLUE;
            sub_cr = CR_BLUE;
        end else begin
            sub_y  = y_in;
            sub_cb = kill ? C_ZERO : cb_in;
            sub_cr = kill ? C_ZERO : cr_in;
        end
    end

    always_comb begin
        use_cb  = (quad_idx == '0) ? sub_cb : grp_cb;
        use_cr  = (quad_idx == '0) ? sub_cr : grp_cr;
        cb_pair = pick_pair(use_cb, quad_idx);
        cr_pair = pick_pair(use_cr, quad_idx);
        if (fmt_411) c_pix = {cb_pair, cr_pair, {PAD_W{1'b0}}};
        else         c_pix = cr_slot ? sub_cr : sub_cb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q    <= Y_BLANK;
            c_q    <= C_ZERO;
            grp_cb <= C_ZERO;
            grp_cr <= C_ZERO;
        end else begin
            if (pix_valid) begin
                y_q <= sub_y;
                c_q <= c_pix;
            end else begin
                y_q <= Y_BLANK;
                c_q <= C_ZERO;
            end
            if (pix_valid && fmt_411 && quad_idx == '0) begin
                grp_cb <= sub_cb;
                grp_cr <= sub_cr;
            end
        end
    end

    // R1: blanking codes follow a cycle with no valid pixel
    p_blank_codes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (y_q == Y_BLANK && c_q == C_ZERO));

    // R6, R7: killed chroma in 4:2:2 is the zero level
    p_kill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && kill && !blue_now && !fmt_411) |=> (c_q == C_ZERO));

    // R8: blue luma wins over the decoded value
    p_blue_luma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && blue_now) |=> (y_q == Y_BLUE));
endmodule

// File: rtl/vof_tap_delay.sv
module vof_tap_delay
    import vof_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      din,
    input  logic [PHASE_W-1:0] sel,
    output logic [DW-1:0]      dout
);
    localparam int TAPS = 1 << PHASE_W;

    logic [DW-1:0] stage [1:TAPS-1];

    for (genvar g = 1; g < TAPS; g++) begin : g_stage
        if (g == 1) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    always_comb begin
        unique case (sel)
            2'b01:   dout = din;
            2'b00:   dout = stage[1];
            2'b11:   dout = stage[2];
            default: dout = stage[3];
        endcase
    end

    // R4: the nominal code lags the undelayed tap by one clock
    p_nominal_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> (dout == $past(din)));
endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
    import vof_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_valid,
    input  logic [7:0]   y_in,
    input  logic [7:0]   cb_in,
    input  logic [7:0]   cr_in,
    input  logic         fmt_411,
    input  logic [1:0]   y_phase,
    input  logic [1:0]   c_phase,
    input  logic         kill_force,
    input  logic         kill_flag,
    input  logic         blue_auto,
    input  logic         sync_ok,
    input  logic         hiz,
    output logic [7:0]   y_out,
    output logic [7:0]   c_out,
    output logic         out_en
);
    logic              cr_slot;
    logic [QUAD_W-1:0] quad_idx;
    logic [DW-1:0]     y_tap0, c_tap0;
    logic              kill, blue_now;

    assign kill     = kill_force | kill_flag;
    assign blue_now = blue_auto & ~sync_ok;

    vof_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .fmt_411   (fmt_411),
        .cr_slot   (cr_slot),
        .quad_idx  (quad_idx)
    );

    vof_pixel_fmt u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .y_in      (y_in),
        .cb_in     (cb_in),
        .cr_in     (cr_in),
        .fmt_411   (fmt_411),
        .cr_slot   (cr_slot),
        .quad_idx  (quad_idx),
        .kill      (kill),
        .blue_now  (blue_now),
        .y_q       (y_tap0),
        .c_q       (c_tap0)
    );

    vof_tap_delay #(.RST_VAL(Y_BLANK)) u_ydly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (y_tap0),
        .sel   (y_phase),
        .dout  (y_out)
    );

    vof_tap_delay #(.RST_VAL(C_ZERO)) u_cdly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (c_tap0),
        .sel   (c_phase),
        .dout  (c_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_en <= 1'b0;
        else        out_en <= ~hiz;
    end

    // R10: float request takes effect after one edge
    p_hiz_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hiz |=> !out_en);

    // R10: drive request takes effect after one edge
    p_drive_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz |=> out_en);
endmodule

// File: tb/vid_out_fmt_bench.sv
module vid_out_fmt_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_valid;
    logic [7:0] y_in, cb_in, cr_in;
    logic       fmt_411;
    logic [1:0] y_phase, c_phase;
    logic       kill_force, kill_flag, blue_auto, sync_ok, hiz;
    logic [7:0] y_out, c_out;
    logic       out_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic       sv [0:79];
    logic [7:0] sy [0:79];
    logic [7:0] scb [0:79];
    logic [7:0] scr [0:79];

    always #2 clk = ~clk;

    vid_out_fmt u_vid_out_fmt (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .fmt_411(fmt_411), .y_phase(y_phase), .c_phase(c_phase),
        .kill_force(kill_force), .kill_flag(kill_flag),
        .blue_auto(blue_auto), .sync_ok(sync_ok), .hiz(hiz),
        .y_out(y_out), .c_out(c_out), .out_en(out_en)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int lat(input logic [1:0] ph);
        case (ph)
            2'b01:   return 1;
            2'b00:   return 2;
            2'b11:   return 3;
            default: return 4;
        endcase
    endfunction

    // fill a ramp stream of n pixels; gaps at positions ga and gb (-1 for none)
    task automatic fill(input int n, input int ga, input int gb);
        for (int i = 0; i < 80; i++) begin
            sv[i]  = (i < n) && (i != ga) && (i != gb);
            sy[i]  = 8'(20 + 7 * i);
            scb[i] = 8'(60 + 13 * i);
            scr[i] = 8'(230 - 11 * i);
        end
    endtask

    // drive the stored stream, compare both buses against the reference model
    task automatic run_stream(input int n, input logic [1:0] py, input logic [1:0] pc,
                              input string tag);
        logic [7:0] oy [0:79];
        logic [7:0] oc [0:79];
        logic [7:0] ey [0:79];
        logic [7:0] ec [0:79];
        logic [7:0] gcb, gcr, vy, vcb, vcr;
        int p, q, ly, lc, steps;
        steps = n + 10;
        p = 0;
        gcb = 8'd128;
        gcr = 8'd128;
        for (int i = 0; i < steps; i++) begin
            if (!sv[i]) begin
                ey[i] = 8'd16;
                ec[i] = 8'd128;
                p = 0;
            end else begin
                if (blue_auto && !sync_ok) begin
                    vy = 8'd29; vcb = 8'd255; vcr = 8'd107;
                end else begin
                    vy  = sy[i];
                    vcb = (kill_force || kill_flag) ? 8'd128 : scb[i];
                    vcr = (kill_force || kill_flag) ? 8'd128 : scr[i];
                end
                ey[i] = vy;
                if (fmt_411) begin
                    q = p % 4;
                    if (q == 0) begin gcb = vcb; gcr = vcr; end
                    ec[i] = {2'((gcb >> (6 - 2 * q)) & 8'd3),
                             2'((gcr >> (6 - 2 * q)) & 8'd3), 4'b0000};
                end else begin
                    ec[i] = (p % 2 == 1) ? vcr : vcb;
                end
                p++;
            end
        end
        for (int s = 0; s < steps; s++) begin
            @(negedge clk);
            oy[s] = y_out;
            oc[s] = c_out;
            y_phase   = py;
            c_phase   = pc;
            pix_valid = sv[s];
            y_in      = sy[s];
            cb_in     = scb[s];
            cr_in     = scr[s];
        end
        ly = lat(py);
        lc = lat(pc);
        for (int i = 0; i < n + 5; i++) begin
            check($sformatf("%s Y pixel %0d", tag, i), int'(oy[i + ly]), int'(ey[i]));
            check($sformatf("%s C pixel %0d", tag, i), int'(oc[i + lc]), int'(ec[i]));
        end
    endtask

    task automatic set_mode(input logic f, input logic kf, input logic kl,
                            input logic ba, input logic so);
        fmt_411 = f; kill_force = kf; kill_flag = kl; blue_auto = ba; sync_ok = so;
    endtask

    // R10: reset state
    task automatic t_reset();
        @(negedge clk);
        check("R10 reset out_en", int'(out_en), 0);
        check("R10 reset y_out", int'(y_out), 16);
        check("R10 reset c_out", int'(c_out), 128);
    endtask

    // R1, R2: 4:2:2 with mid-line gaps
    task automatic t_422();
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        fill(20, 7, 8);
        run_stream(20, 2'b00, 2'b00, "R2 R1 gap422");
        fill(15, 4, -1);
        run_stream(15, 2'b00, 2'b00, "R2 R1 oddgap");
    endtask

    // R3: 4:1:1 with a gap inside a group
    task automatic t_411();
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        fill(24, 10, -1);
        run_stream(24, 2'b00, 2'b00, "R3 pack411");
    endtask

    // R4, R5: every phase code, different codes on the two buses
    task automatic t_phase();
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        fill(16, 9, -1);
        run_stream(16, 2'b01, 2'b10, "R4 R5 y01c10");
        run_stream(16, 2'b11, 2'b00, "R4 R5 y11c00");
        run_stream(16, 2'b10, 2'b01, "R4 R5 y10c01");
        run_stream(16, 2'b00, 2'b11, "R4 R5 y00c11");
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run_stream(16, 2'b10, 2'b01, "R4 R3 y10c01");
    endtask

    // R6, R7: colour killing
    task automatic t_kill();
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        fill(12, -1, -1);
        run_stream(12, 2'b00, 2'b00, "R6 force422");
        set_mode(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        run_stream(12, 2'b00, 2'b00, "R7 flag411");
    endtask

    // R8, R9: blue screen
    task automatic t_blue();
        set_mode(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        fill(12, 5, -1);
        run_stream(12, 2'b00, 2'b00, "R8 blue_over_kill");
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_stream(12, 2'b00, 2'b00, "R9 off_nosync");
        set_mode(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        run_stream(12, 2'b00, 2'b00, "R9 auto_sync");
    endtask

    // R10: tri-state request
    task automatic t_hiz();
        @(negedge clk);
        check("R10 active out_en", int'(out_en), 1);
        hiz = 1'b1;
        @(negedge clk);
        check("R10 hiz out_en", int'(out_en), 0);
        @(negedge clk);
        check("R10 hiz held", int'(out_en), 0);
        hiz = 1'b0;
        @(negedge clk);
        check("R10 reenable out_en", int'(out_en), 1);
    endtask

    initial begin
        rst_n = 1'b0; pix_valid = 1'b0; y_in = '0; cb_in = '0; cr_in = '0;
        y_phase = 2'b00; c_phase = 2'b00; hiz = 1'b0;
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_hiz();
        t_422();
        t_411();
        t_phase();
        t_kill();
        t_blue();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule